// File: doc/BRIEF.md
# Serial Leaky Integrate-and-Fire Reservoir Engine

This block advances a small population of leaky integrate-and-fire neurons by one network time step whenever it is told to start. One shared datapath visits the neurons in ascending index order. For each neuron it reads the synapse and membrane accumulators from a state memory, sums the fixed weights of every active spike source into the synapse accumulator, integrates the synapse accumulator into the membrane, applies exponential leak to both, compares the membrane against a threshold, and writes the results back.

Spike sources are the external input lines, which are latched when the step starts, and the spikes the neurons themselves produced in the previous step. Fixed connection weights come from a weight table computed at elaboration time. Each neuron visit produces one record on the spike output stream, and a single-cycle done flag closes the step. The block suits reservoir-style networks in which only an external readout is trained.

Top module: `lif_reservoir_engine`

## Requirements
- R1: After reset, `spk_valid` and `step_done` are low, and every synapse and membrane accumulator holds zero. A first step with no input spikes therefore reports membrane 0 and no spike for every neuron.
- R2: `step_start` is accepted only while the engine is idle. On acceptance, `in_spikes`, `syn_shift`, `mem_shift` and `threshold` are latched for the whole step. A strobe that arrives while a step is running, or in the cycle in which `step_done` is high, is ignored: no extra records and no extra done pulse follow.
- R3: Each step emits exactly N_NEURONS records on the stream. A record is a cycle with `spk_valid` high, and the records carry `spk_id` 0, 1, ... N_NEURONS-1 in that order.
- R4: Each neuron takes N_INPUTS+N_NEURONS+2 cycles. `step_done` is high exactly N_NEURONS*(N_INPUTS+N_NEURONS+2)+1 cycles after the clock edge that accepts the strobe, and it is high in the cycle right after the last record.
- R5: Spike sources are numbered as follows. Sources 0..N_INPUTS-1 are the `in_spikes` bits. Source N_INPUTS+j is neuron j's spike from the previous step. For neuron d, each active source s adds the weight (((5*s+3*d) mod 11) - 3)*W_UNIT to the synapse accumulator. The additions are made in ascending source order, and each one saturates.
- R6: After the input sums, the synapse accumulator (before leak) is added to the membrane with saturation.
- R7: Leak is then applied as x - (x >>> k), using an arithmetic shift. For the synapse accumulator k = `syn_shift`; for the membrane k = `mem_shift`.
- R8: A neuron spikes when its leaked membrane is greater than `threshold` (signed). The record then shows `spk_fire`=1 and `spk_mem`=0, and the membrane is stored as 0. Otherwise `spk_fire`=0, and `spk_mem` shows the leaked membrane, which is also the stored value.
- R9: A spike produced in step t acts as an input source only in step t+1, never later within step t.
- R10: Accumulators are signed 16-bit and clamp at 32767 and -32768 instead of wrapping.
- R11: `step_done` is a one-cycle pulse and never coincides with a stream record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_start | input | 1 | Strobe that begins a network time step |
| in_spikes | input | N_INPUTS | External spike sources for the step |
| syn_shift | input | 4 | Leak shift for synapse accumulators |
| mem_shift | input | 4 | Leak shift for membranes |
| threshold | input | 16 | Signed firing threshold |
| spk_valid | output | 1 | A neuron record is present |
| spk_id | output | log2(N_NEURONS) | Index of the neuron in the record |
| spk_fire | output | 1 | The neuron spiked this step |
| spk_mem | output | 16 | Membrane value written back |
| step_done | output | 1 | One-cycle end-of-step flag |

## Verification
The checker compares non-spiking records against the `threshold` port, not against the latched copy. It therefore assumes that `threshold` stays constant for the duration of a step. The bench changes threshold, shift values and input spikes only between steps, after `step_done`, and the only strobes it sends while a step is running are the deliberate ones that test R2. Reset is applied once at time zero, before any strobe is sent.

// File: rtl/lif_pkg.sv
package lif_pkg;
  localparam int ACC_W   = 16;
  localparam int SHIFT_W = 4;

  typedef logic signed [ACC_W-1:0] acc_t;
  typedef enum logic [2:0] {PH_IDLE, PH_FETCH, PH_ACC, PH_WRITE, PH_DONE} phase_t;

  localparam acc_t ACC_MAX = acc_t'((2 ** (ACC_W - 1)) - 1);
  localparam acc_t ACC_MIN = acc_t'(-(2 ** (ACC_W - 1)));

  function automatic acc_t sat_add(acc_t a, acc_t b);
    logic signed [ACC_W:0] s;
    s = {a[ACC_W-1], a} + {b[ACC_W-1], b};
    if (s[ACC_W] != s[ACC_W-1]) return s[ACC_W] ? ACC_MIN : ACC_MAX;
    return s[ACC_W-1:0];
  endfunction

  function automatic acc_t leak(acc_t x, logic [SHIFT_W-1:0] k);
    return x - (x >>> k);
  endfunction

  function automatic acc_t weight_of(int src, int dst, int unit);
    int v;
    v = (((src * 5 + dst * 3) % 11) - 3) * unit;
    return acc_t'(v);
  endfunction
endpackage

// File: rtl/lif_weight_rom.sv
module lif_weight_rom import lif_pkg::*; #(
  parameter int N_NEURONS = 8,
  parameter int N_INPUTS  = 4,
  parameter int W_UNIT    = 16
) (
  input  logic [$clog2(N_INPUTS+N_NEURONS)-1:0] src,
  input  logic [$clog2(N_NEURONS)-1:0]          dst,
  output acc_t                                  weight
);
  localparam int SRC_N = N_INPUTS + N_NEURONS;

  acc_t tbl [SRC_N][N_NEURONS];

  for (genvar s = 0; s < SRC_N; s++) begin : g_src
    for (genvar d = 0; d < N_NEURONS; d++) begin : g_dst
      assign tbl[s][d] = weight_of(s, d, W_UNIT);
    end
  end

  assign weight = tbl[src][dst];
endmodule

// File: rtl/lif_state_ram.sv
module lif_state_ram import lif_pkg::*; #(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output acc_t                     rd_syn,
  output acc_t                     rd_mem,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  acc_t                     wr_syn,
  input  acc_t                     wr_mem
);
  acc_t syn_arr [DEPTH];
  acc_t mem_arr [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        syn_arr[i] <= '0;
        mem_arr[i] <= '0;
      end
    end else if (wr_en) begin
      syn_arr[wr_addr] <= wr_syn;
      mem_arr[wr_addr] <= wr_mem;
    end
  end

  assign rd_syn = syn_arr[rd_addr];
  assign rd_mem = mem_arr[rd_addr];
endmodule

// File: rtl/lif_neuron_alu.sv
module lif_neuron_alu import lif_pkg::*; (
  input  acc_t               syn_in,
  input  acc_t               mem_in,
  input  logic [SHIFT_W-1:0] syn_k,
  input  logic [SHIFT_W-1:0] mem_k,
  input  acc_t               thr,
  output acc_t               syn_out,
  output acc_t               mem_out,
  output logic               fire
);
  acc_t mem_sum;
  acc_t mem_leaked;

  always_comb begin
    mem_sum    = sat_add(mem_in, syn_in);
    syn_out    = leak(syn_in, syn_k);
    mem_leaked = leak(mem_sum, mem_k);
    fire       = (mem_leaked > thr);
    mem_out    = fire ? '0 : mem_leaked;
  end
endmodule

// File: rtl/lif_reservoir_engine.sv
module lif_reservoir_engine import lif_pkg::*; #(
  parameter int N_NEURONS = 8,
  parameter int N_INPUTS  = 4,
  parameter int W_UNIT    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          step_start,
  input  logic [N_INPUTS-1:0]           in_spikes,
  input  logic [SHIFT_W-1:0]            syn_shift,
  input  logic [SHIFT_W-1:0]            mem_shift,
  input  logic [ACC_W-1:0]              threshold,
  output logic                          spk_valid,
  output logic [$clog2(N_NEURONS)-1:0]  spk_id,
  output logic                          spk_fire,
  output logic [ACC_W-1:0]              spk_mem,
  output logic                          step_done
);
  localparam int SRC_N = N_INPUTS + N_NEURONS;
  localparam int IDW   = $clog2(N_NEURONS);
  localparam int SW    = $clog2(SRC_N);
  localparam logic [IDW-1:0] LAST_N = IDW'(N_NEURONS - 1);
  localparam logic [SW-1:0]  LAST_S = SW'(SRC_N - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  phase_t                phase_q, phase_d;
  logic [IDW-1:0]        nidx_q, nidx_d;
  logic [SW-1:0]         sidx_q, sidx_d;
  acc_t                  syn_acc_q, syn_acc_d;
  logic [N_INPUTS-1:0]   ext_q;
  logic [N_NEURONS-1:0]  prev_q, cur_q, cur_d;
  logic [SHIFT_W-1:0]    ks_q, km_q;
  acc_t                  thr_q;
  logic                  cfg_ld;
  logic                  busy;

  logic [SRC_N-1:0]      src_vec;
  acc_t                  w_cur;
  acc_t                  ram_syn, ram_mem;
  acc_t                  new_syn, new_mem;
  logic                  new_fire;
  logic                  wr_en;

  assign src_vec = {prev_q, ext_q};
  assign wr_en   = (phase_q == PH_WRITE);
  assign busy    = (phase_q != PH_IDLE);

  lif_weight_rom #(.N_NEURONS(N_NEURONS), .N_INPUTS(N_INPUTS), .W_UNIT(W_UNIT)) u_wrom (
    .src(sidx_q), .dst(nidx_q), .weight(w_cur)
  );

  lif_state_ram #(.DEPTH(N_NEURONS)) u_sram (
    .clk(clk), .rst_n(rst_i),
    .rd_addr(nidx_q), .rd_syn(ram_syn), .rd_mem(ram_mem),
    .wr_en(wr_en), .wr_addr(nidx_q), .wr_syn(new_syn), .wr_mem(new_mem)
  );

  lif_neuron_alu u_alu (
    .syn_in(syn_acc_q), .mem_in(ram_mem), .syn_k(ks_q), .mem_k(km_q), .thr(thr_q),
    .syn_out(new_syn), .mem_out(new_mem), .fire(new_fire)
  );

  // next-state
  always_comb begin
    phase_d   = phase_q;
    nidx_d    = nidx_q;
    sidx_d    = sidx_q;
    syn_acc_d = syn_acc_q;
    cur_d     = cur_q;
    cfg_ld    = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (step_start) begin
          phase_d = PH_FETCH;
          nidx_d  = '0;
          cfg_ld  = 1'b1;
        end
      end
      PH_FETCH: begin
        syn_acc_d = ram_syn;
        sidx_d    = '0;
        phase_d   = PH_ACC;
      end
      PH_ACC: begin
        if (src_vec[sidx_q]) syn_acc_d = sat_add(syn_acc_q, w_cur);
        if (sidx_q == LAST_S) phase_d = PH_WRITE;
        else                  sidx_d  = sidx_q + 1'b1;
      end
      PH_WRITE: begin
        cur_d[nidx_q] = new_fire;
        if (nidx_q == LAST_N) phase_d = PH_DONE;
        else begin
          nidx_d  = nidx_q + 1'b1;
          phase_d = PH_FETCH;
        end
      end
      PH_DONE:  phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      phase_q   <= PH_IDLE;
      nidx_q    <= '0;
      sidx_q    <= '0;
      syn_acc_q <= '0;
      cur_q     <= '0;
    end else begin
      phase_q   <= phase_d;
      nidx_q    <= nidx_d;
      sidx_q    <= sidx_d;
      syn_acc_q <= syn_acc_d;
      cur_q     <= cur_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ext_q  <= '0;
      prev_q <= '0;
      ks_q   <= '0;
      km_q   <= '0;
      thr_q  <= '0;
    end else if (cfg_ld) begin
      ext_q  <= in_spikes;
      prev_q <= cur_q;
      ks_q   <= syn_shift;
      km_q   <= mem_shift;
      thr_q  <= acc_t'(threshold);
    end
  end

  assign spk_valid = wr_en;
  assign spk_id    = nidx_q;
  assign spk_fire  = wr_en & new_fire;
  assign spk_mem   = new_mem;
  assign step_done = (phase_q == PH_DONE);
endmodule

// File: rtl/lif_engine_checker.sv
module lif_engine_checker #(
  parameter int N_NEURONS = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         step_start,
  input logic                         busy,
  input logic [15:0]                  threshold,
  input logic                         spk_valid,
  input logic [$clog2(N_NEURONS)-1:0] spk_id,
  input logic                         spk_fire,
  input logic [15:0]                  spk_mem,
  input logic                         step_done
);
  localparam int IDW = $clog2(N_NEURONS);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> !step_done);

  // R11
  done_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_done && spk_valid));

  // R4
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> ($past(spk_valid) && ($past(spk_id) == IDW'(N_NEURONS - 1))));

  // R8
  fire_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spk_fire |-> (spk_valid && spk_mem == 16'd0));

  // R8
  below_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spk_valid && !spk_fire) |-> ($signed(spk_mem) <= $signed(threshold)));

  // R2
  done_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> !busy);

  // R2
  idle_accepts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && step_start && $past(busy) == 1'b0 && !$past(step_done)) |=> busy);
endmodule

bind lif_reservoir_engine lif_engine_checker #(.N_NEURONS(N_NEURONS)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_start(step_start), .busy(busy),
  .threshold(threshold), .spk_valid(spk_valid), .spk_id(spk_id),
  .spk_fire(spk_fire), .spk_mem(spk_mem), .step_done(step_done)
);

// File: tb/lif_reservoir_engine_bench.sv
module lif_reservoir_engine_bench;
  localparam int N  = 8;
  localparam int NI = 4;
  localparam int S  = N + NI;
  localparam int STEP_CYC = N * (S + 2) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_start = 1'b0;
  logic [NI-1:0] in_spikes = '0;
  logic [3:0] syn_shift = 4'd2;
  logic [3:0] mem_shift = 4'd3;
  logic [15:0] threshold = 16'd200;
  logic spk_valid, spk_fire, step_done;
  logic [2:0] spk_id;
  logic [15:0] spk_mem;

  int checks = 0;
  int fails  = 0;
  int syn_m [N];
  int mem_m [N];
  bit prevf [N];
  int last_mem [N];

  always #5 clk = ~clk;

  lif_reservoir_engine #(.N_NEURONS(N), .N_INPUTS(NI), .W_UNIT(16)) u_lif_reservoir_engine (
    .clk(clk), .rst_n(rst_n), .step_start(step_start), .in_spikes(in_spikes),
    .syn_shift(syn_shift), .mem_shift(mem_shift), .threshold(threshold),
    .spk_valid(spk_valid), .spk_id(spk_id), .spk_fire(spk_fire),
    .spk_mem(spk_mem), .step_done(step_done)
  );

  function automatic int sat(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int wgt(int s, int d);
    return (((s * 5 + d * 3) % 11) - 3) * 16;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one network step: model, drive, compare; glitch_at pulses a stray strobe
  task automatic run_step(logic [NI-1:0] ext, int ks, int km, int thr, int glitch_at);
    int  exp_mem [N];
    bit  exp_fire [N];
    int  cnt = 0;
    int  rec = 0;
    for (int d = 0; d < N; d++) begin
      int s = syn_m[d];
      int m;
      for (int src = 0; src < S; src++) begin
        bit act = (src < NI) ? ext[src] : prevf[src - NI];   // R5, R9
        if (act) s = sat(s + wgt(src, d));                    // R10
      end
      m = sat(mem_m[d] + s);                                  // R6
      s = s - (s >>> ks);                                     // R7
      m = m - (m >>> km);
      exp_fire[d] = (m > thr);                                // R8
      if (exp_fire[d]) m = 0;
      syn_m[d] = s;
      exp_mem[d] = m;
    end
    @(negedge clk);
    in_spikes = ext; syn_shift = 4'(ks); mem_shift = 4'(km); threshold = 16'(thr);
    step_start = 1'b1;
    while (1) begin
      @(negedge clk);
      cnt++;
      step_start = (cnt == glitch_at);
      if (spk_valid) begin
        if (rec < N) begin
          check(spk_id == 3'(rec), "R3 order", int'(spk_id), rec);
          check(spk_fire == exp_fire[rec], "R8/R9 fire", int'(spk_fire), int'(exp_fire[rec]));
          check(int'($signed(spk_mem)) == exp_mem[rec], "R5/R6/R7 membrane",
                int'($signed(spk_mem)), exp_mem[rec]);
          last_mem[rec] = int'($signed(spk_mem));
        end
        rec++;
      end
      if (step_done || cnt > 4 * STEP_CYC) break;
    end
    check(cnt == STEP_CYC, "R4 done latency", cnt, STEP_CYC);
    check(rec == N, "R3 record count", rec, N);
    step_start = 1'b0;
    // R2 R11: nothing may follow the done pulse
    rec = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (spk_valid || step_done) rec++;
    end
    check(rec == 0, "R2/R11 quiet after done", rec, 0);
    for (int d = 0; d < N; d++) begin
      mem_m[d] = exp_mem[d];
      prevf[d] = exp_fire[d];
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(spk_valid == 1'b0, "R1 valid low", int'(spk_valid), 0);
    check(step_done == 1'b0, "R1 done low", int'(step_done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(spk_valid == 1'b0 && step_done == 1'b0, "R1 idle after release",
          int'(spk_valid) + int'(step_done), 0);
  endtask

  task automatic t_quiet();            // R1: zeroed state, no input
    run_step('0, 2, 3, 200, 0);
  endtask

  task automatic t_single_input();     // R5 R6 R7
    for (int i = 0; i < 4; i++) run_step(4'b0001, 2, 3, 200, 0);
  endtask

  task automatic t_recurrent();        // R8 R9
    for (int i = 0; i < 6; i++) run_step(4'b1111, 2, 2, 100, 0);
    for (int i = 0; i < 3; i++) run_step(4'b0000, 1, 1, 100, 0);
  endtask

  task automatic t_shift_modes();      // R7
    run_step(4'b1010, 0, 1, 150, 0);
    run_step(4'b0110, 5, 0, 150, 0);
    run_step(4'b1001, 1, 4, -50, 0);
  endtask

  task automatic t_ignore_strobe();    // R2
    run_step(4'b0101, 2, 3, 120, 20);
    run_step(4'b1100, 2, 3, 120, 60);
    run_step(4'b0011, 2, 3, 120, STEP_CYC);
  endtask

  task automatic t_saturate();         // R10
    for (int i = 0; i < 40; i++) run_step(4'b1111, 15, 15, 32767, 0);
    check(last_mem[0] == 32767, "R10 membrane clamps high", last_mem[0], 32767);
  endtask

  initial begin
    for (int d = 0; d < N; d++) begin
      syn_m[d] = 0; mem_m[d] = 0; prevf[d] = 0; last_mem[d] = 0;
    end
    t_reset();
    t_quiet();
    t_single_input();
    t_recurrent();
    t_shift_modes();
    t_ignore_strobe();
    t_saturate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule